// File: doc/BRIEF.md
# Byte-Level Serial Save Memory

This block behaves like the save chip of a cartridge as seen by a host that talks to it one byte at a time over a serial link. For every byte the host sends, the block returns one response byte on the following clock cycle. The bit-level shifting is done elsewhere; this block only interprets whole bytes and keeps the stored contents in an internal byte array. Unwritten locations read as 0xFF.

The first byte of each transaction is the opcode. The host ends a transaction with a serial-mode configuration write. A chip-select hold flag in that write keeps the opcode alive across the next configuration write. Opcodes for the status register take no address. Data opcodes are followed by an address sent most significant byte first, whose length comes from the configured memory kind, and then by data bytes. The address advances by one after each data byte. Writes are committed only while the write-enable status bit is set. That bit drops when a transaction that committed a write is closed.

Top module: `spi_save_mem`

## Requirements
- R1: After reset `resp_valid` is low and `mem_kind` is 0. Each cycle with `xfer_valid` high gives exactly one cycle of `resp_valid` high on the next cycle, carrying the response to that byte. No `resp_valid` appears without a byte.
- R2: The first byte after a transaction is closed is latched as the opcode and answered with 0xFF. The address register is cleared at that point.
- R3: After a data opcode, memory kind 3 (flash) takes three address bytes and kinds 0, 1 and 2 take two. The address bytes arrive most significant first, and each is answered with 0xFF.
- R4: Status register bit 1 is write enable and all its other bits read 0. On each byte after opcode 0x06 the bit is set. On each byte after 0x04 it is cleared. Each byte after 0x05 returns the status register.
- R5: Opcode 0x03 returns the stored byte at the current address for each data byte, then advances the address by one.
- R6: Opcode 0x02 answers each data byte with 0xFF and advances the address. It stores the byte only while write enable is set.
- R7: With kind 3, opcode 0x0A returns the previous content of the current address, stores the new byte there when write enable is set, and advances the address. With any other kind, its data bytes answer 0xFF and store nothing.
- R8: A location never written reads 0xFF. Any opcode outside 0x02, 0x03, 0x04, 0x05, 0x06 and 0x0A answers every byte with 0xFF.
- R9: A configuration write with `cfg_serial` high closes the current transaction only if the hold flag stored by the previous such write was low. It then stores `cfg_hold` as the new hold flag, so a held transaction continues at the next address.
- R10: When a transaction that committed at least one write is closed, write enable clears. A transaction without a committed write leaves it unchanged.
- R11: An opcode byte of 0x0B while `mem_kind` is 0 (undetermined) changes `mem_kind` to 1 (small EEPROM). It leaves any other kind unchanged.
- R12: Addresses past the end of the array wrap modulo `MEM_BYTES`, both when given directly and when reached by advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_valid | input | 1 | Host byte present this cycle |
| xfer_din | input | 8 | Host byte |
| cfg_wr | input | 1 | Configuration write strobe, never in the same cycle as `xfer_valid` |
| cfg_serial | input | 1 | Configuration selects serial mode |
| cfg_hold | input | 1 | Chip-select hold flag of the configuration write |
| kind_wr | input | 1 | Load the memory kind |
| kind_in | input | 2 | Memory kind: 0 undetermined, 1 small EEPROM, 2 EEPROM, 3 flash |
| resp_valid | output | 1 | Response byte valid |
| resp_dout | output | 8 | Response byte |
| mem_kind | output | 2 | Current memory kind |

## Verification
The bench builds the block with `MEM_BYTES` set to 64, so a single burst sweeps every location. It programs a pattern computed from the index into all 64 bytes, reads it back, and then reads on past the end to show the wrap. A three-byte flash address whose upper bytes lie beyond the array checks both the byte order and the modulo wrap. The small array also lets each opcode be run under both memory kinds and both write-enable states, including held transactions and the 0x0B kind change.

// File: rtl/spi_save_pkg.sv
// Shared opcodes, memory kinds and helpers for the serial save memory.
package spi_save_pkg;

    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WRDIS   = 8'h04;
    localparam logic [7:0] OP_RDSTAT  = 8'h05;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_PWRITE  = 8'h0A;
    localparam logic [7:0] OP_PROBE   = 8'h0B;
    localparam logic [7:0] BYTE_IDLE  = 8'hFF;
    localparam int         ADDR_W     = 24;

    typedef enum logic [1:0] {
        KIND_UNSET = 2'd0,
        KIND_SMALL = 2'd1,
        KIND_EEP   = 2'd2,
        KIND_FLASH = 2'd3
    } mem_kind_e;

    // Number of address bytes a memory kind expects after a data opcode.
    function automatic logic [1:0] addr_bytes(input mem_kind_e k);
        return (k == KIND_FLASH) ? 2'd3 : 2'd2;
    endfunction

    // True for opcodes that act on the status register and take no address.
    function automatic logic is_status_op(input logic [7:0] op);
        return (op == OP_WRDIS) || (op == OP_RDSTAT) || (op == OP_WREN);
    endfunction

endpackage

// File: rtl/spi_save_store.sv
// Byte array backing the save memory.
// Reads are combinational at the given index; a write lands at the clock
// edge, so a read in the same cycle still sees the previous content.
// Assumes DEPTH is a power of two. Reset fills the array with the erased value.
module spi_save_store #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data
);
    import spi_save_pkg::*;

    logic [7:0] cells [DEPTH];

    // Erase on reset, otherwise take the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= BYTE_IDLE;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    // Combinational read port.
    assign rd_data = cells[idx];

    // R6: a committed byte is visible at its location on the next cycle.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && (idx == $past(idx))) |-> (rd_data == $past(wdata)));

endmodule

// File: rtl/spi_save_ctrl.sv
// Transaction engine of the serial save memory.
// Latches the opcode, collects the address MSB first, runs the status
// commands and the data phase, and registers one response per host byte.
// Assumes cfg_wr and xfer_valid never coincide; the store reads combinationally.
module spi_save_ctrl #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_valid,
    input  logic [7:0]       xfer_din,
    input  logic             cfg_wr,
    input  logic             cfg_serial,
    input  logic             cfg_hold,
    input  logic             kind_wr,
    input  logic [1:0]       kind_in,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] st_idx,
    output logic             st_we,
    output logic [7:0]       st_wdata,
    output logic             resp_valid,
    output logic [7:0]       resp_dout,
    output logic [1:0]       kind_out
);
    import spi_save_pkg::*;

    logic [7:0]        cmd_q;
    logic              cmd_vld;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        addr_left;
    logic              wen_q;
    logic              wrote_q;
    logic              hold_q;
    mem_kind_e         kind_q;
    logic [7:0]        resp_q;
    logic              resp_vld;

    logic              data_phase;
    logic              pw_ok;
    logic              closing;
    logic [7:0]        status_val;

    // Decode of the current byte's role.
    always_comb begin
        data_phase = xfer_valid && cmd_vld && !is_status_op(cmd_q) && (addr_left == 2'd0);
        pw_ok      = (cmd_q == OP_PWRITE) && (kind_q == KIND_FLASH);
        closing    = cfg_wr && cfg_serial && !hold_q;
        status_val = 8'h00;
        status_val[1] = wen_q;
    end

    // Store port: index from the low address bits, write gated by enable.
    always_comb begin
        st_idx   = addr_q[IDX_W-1:0];
        st_wdata = xfer_din;
        st_we    = data_phase && wen_q && ((cmd_q == OP_PROG) || pw_ok);
    end

    // Transaction state, status register and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= 8'h00;
            cmd_vld   <= 1'b0;
            addr_q    <= '0;
            addr_left <= 2'd0;
            wen_q     <= 1'b0;
            wrote_q   <= 1'b0;
            hold_q    <= 1'b0;
            kind_q    <= KIND_UNSET;
            resp_q    <= BYTE_IDLE;
            resp_vld  <= 1'b0;
        end else begin
            resp_vld <= xfer_valid;
            if (kind_wr) kind_q <= mem_kind_e'(kind_in);
            if (cfg_wr && cfg_serial) begin
                if (closing) begin
                    cmd_vld <= 1'b0;
                    if (wrote_q) begin
                        wen_q   <= 1'b0;
                        wrote_q <= 1'b0;
                    end
                end
                hold_q <= cfg_hold;
            end else if (xfer_valid) begin
                resp_q <= BYTE_IDLE;
                if (!cmd_vld) begin
                    cmd_q     <= xfer_din;
                    cmd_vld   <= 1'b1;
                    addr_q    <= '0;
                    addr_left <= addr_bytes(kind_q);
                    if (xfer_din == OP_PROBE && kind_q == KIND_UNSET && !kind_wr)
                        kind_q <= KIND_SMALL;
                end else if (is_status_op(cmd_q)) begin
                    case (cmd_q)
                        OP_WREN:   wen_q  <= 1'b1;
                        OP_WRDIS:  wen_q  <= 1'b0;
                        default:   resp_q <= status_val;
                    endcase
                end else if (addr_left != 2'd0) begin
                    addr_q    <= {addr_q[ADDR_W-9:0], xfer_din};
                    addr_left <= addr_left - 2'd1;
                end else begin
                    case (cmd_q)
                        OP_READ: begin
                            resp_q <= rd_data;
                            addr_q <= addr_q + 1'b1;
                        end
                        OP_PROG: begin
                            addr_q <= addr_q + 1'b1;
                            if (wen_q) wrote_q <= 1'b1;
                        end
                        OP_PWRITE: begin
                            if (pw_ok) begin
                                resp_q <= rd_data;
                                addr_q <= addr_q + 1'b1;
                                if (wen_q) wrote_q <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign resp_valid = resp_vld;
    assign resp_dout  = resp_q;
    assign kind_out   = kind_q;

    // R1: the two request sources never coincide.
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_valid && cfg_wr));
    // R1: every byte gets a response one cycle later.
    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> resp_valid);
    // R1: no response without a byte.
    a_r1_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> !resp_valid);
    // R2: an opcode is taken only from a host byte, with the address cleared.
    a_r2_cmd_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_vld) |-> ($past(xfer_valid) && addr_q == '0));
    // R9: a transaction ends only through an unheld serial configuration write.
    a_r9_cmd_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_vld) |-> $past(cfg_wr && cfg_serial && !hold_q));
    // R10: write enable drops only on a close or a disable opcode.
    a_r10_wen_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen_q) |-> ($past(cfg_wr) || $past(xfer_valid && cmd_vld && cmd_q == OP_WRDIS)));
    // R5: a read data byte advances the address by one.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && cmd_q == OP_READ) |=> (addr_q == $past(addr_q) + 1'b1));
    // R11: a determined kind changes only through a kind load.
    a_r11_kind_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q != KIND_UNSET && !kind_wr) |=> $stable(kind_q));

endmodule

// File: rtl/spi_save_mem.sv
// Top of the byte-level serial save memory: transaction engine plus array.
// Assumes MEM_BYTES is a power of two no larger than the 24-bit address space.
module spi_save_mem #(
    parameter int MEM_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_valid,
    input  logic [7:0] xfer_din,
    input  logic       cfg_wr,
    input  logic       cfg_serial,
    input  logic       cfg_hold,
    input  logic       kind_wr,
    input  logic [1:0] kind_in,
    output logic       resp_valid,
    output logic [7:0] resp_dout,
    output logic [1:0] mem_kind
);
    localparam int IDX_W = $clog2(MEM_BYTES);

    logic [IDX_W-1:0] st_idx;
    logic             st_we;
    logic [7:0]       st_wdata;
    logic [7:0]       rd_data;

    spi_save_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_valid (xfer_valid),
        .xfer_din   (xfer_din),
        .cfg_wr     (cfg_wr),
        .cfg_serial (cfg_serial),
        .cfg_hold   (cfg_hold),
        .kind_wr    (kind_wr),
        .kind_in    (kind_in),
        .rd_data    (rd_data),
        .st_idx     (st_idx),
        .st_we      (st_we),
        .st_wdata   (st_wdata),
        .resp_valid (resp_valid),
        .resp_dout  (resp_dout),
        .kind_out   (mem_kind)
    );

    spi_save_store #(.DEPTH(MEM_BYTES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (st_idx),
        .we      (st_we),
        .wdata   (st_wdata),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_spi_save_mem.sv
module sim_spi_save_mem;
    localparam int N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xv = 1'b0;
    logic [7:0] xd = 8'h00;
    logic       cw = 1'b0, cs = 1'b0, ch = 1'b0;
    logic       kw = 1'b0;
    logic [1:0] ki = 2'd0;
    logic       resp_valid;
    logic [7:0] resp_dout;
    logic [1:0] mem_kind;

    int checks = 0;
    int errors = 0;
    logic [7:0] r;

    always #10 clk = ~clk;

    spi_save_mem #(.MEM_BYTES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xv), .xfer_din(xd),
        .cfg_wr(cw), .cfg_serial(cs), .cfg_hold(ch),
        .kind_wr(kw), .kind_in(ki),
        .resp_valid(resp_valid), .resp_dout(resp_dout), .mem_kind(mem_kind)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Send one byte, return the response seen one cycle later.
    task automatic xb(input logic [7:0] d, output logic [7:0] rr);
        @(negedge clk); xv = 1'b1; xd = d;
        @(negedge clk); xv = 1'b0;
        chk("R1 resp_valid", {7'd0, resp_valid}, 8'd1);
        rr = resp_dout;
    endtask

    task automatic cfg(input logic hold);
        @(negedge clk); cw = 1'b1; cs = 1'b1; ch = hold;
        @(negedge clk); cw = 1'b0;
    endtask

    task automatic set_kind(input logic [1:0] k);
        @(negedge clk); kw = 1'b1; ki = k;
        @(negedge clk); kw = 1'b0;
    endtask

    // Close, send opcode, send address (3 bytes when flash).
    task automatic open_at(input logic [7:0] op, input logic flash, input logic [23:0] a);
        logic [7:0] q;
        cfg(1'b0);
        xb(op, q); chk("R2 opcode resp", q, 8'hFF);
        if (flash) begin xb(a[23:16], q); chk("R3 addr resp", q, 8'hFF); end
        xb(a[15:8], q); chk("R3 addr resp", q, 8'hFF);
        xb(a[7:0], q);  chk("R3 addr resp", q, 8'hFF);
    endtask

    task automatic status_op(input logic [7:0] op, output logic [7:0] rr);
        logic [7:0] q;
        cfg(1'b0);
        xb(op, q);
        xb(8'h00, rr);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset resp_valid", {7'd0, resp_valid}, 8'd0);
        chk("R1 reset kind", {6'd0, mem_kind}, 8'd0);
        @(negedge clk);
        chk("R1 quiet", {7'd0, resp_valid}, 8'd0);

        set_kind(2'd3);
        // R8: erased sweep
        open_at(8'h03, 1'b1, 24'h0);
        for (int i = 0; i < N; i++) begin xb(8'h00, r); chk("R8 erased", r, 8'hFF); end

        // R6: program without write enable stores nothing
        open_at(8'h02, 1'b1, 24'h0);
        xb(8'h55, r); chk("R6 prog resp", r, 8'hFF);
        open_at(8'h03, 1'b1, 24'h0);
        xb(8'h00, r); chk("R6 no store w/o enable", r, 8'hFF);

        // R4: enable, then status survives a close without write (R10)
        status_op(8'h06, r); chk("R4 wren resp", r, 8'hFF);
        status_op(8'h05, r); chk("R4 status after wren", r, 8'h02);
        xb(8'h00, r);        chk("R4 status repeat", r, 8'h02);

        // R6: full program sweep
        open_at(8'h02, 1'b1, 24'h0);
        for (int i = 0; i < N; i++) begin xb(pat(i), r); chk("R6 prog resp", r, 8'hFF); end
        status_op(8'h05, r); chk("R10 wen cleared after write", r, 8'h00);

        // R5 read sweep, then R12 wrap by advancing
        open_at(8'h03, 1'b1, 24'h0);
        for (int i = 0; i < 2 * N; i++) begin xb(8'h00, r); chk("R5 R12 read", r, pat(i % N)); end

        // R3 MSB first, R12 wrap of a direct address
        open_at(8'h03, 1'b1, 24'h000105);
        xb(8'h00, r); chk("R3 R12 addr order/wrap", r, pat(5));

        // R4 disable
        status_op(8'h06, r);
        status_op(8'h04, r); chk("R4 wrdis resp", r, 8'hFF);
        status_op(8'h05, r); chk("R4 status after wrdis", r, 8'h00);

        // R7 page write on flash
        status_op(8'h06, r);
        open_at(8'h0A, 1'b1, 24'h000002);
        xb(8'hAA, r); chk("R7 old byte", r, pat(2));
        xb(8'hBB, r); chk("R7 old byte next", r, pat(3));
        open_at(8'h03, 1'b1, 24'h000002);
        xb(8'h00, r); chk("R7 new byte", r, 8'hAA);
        xb(8'h00, r); chk("R7 new byte next", r, 8'hBB);

        // R9 hold keeps the transaction across a configuration write
        status_op(8'h06, r);
        cfg(1'b1);
        xb(8'h02, r); xb(8'h00, r); xb(8'h00, r); xb(8'h10, r);
        xb(8'h11, r);
        cfg(1'b0);
        xb(8'h22, r); chk("R9 held data resp", r, 8'hFF);
        cfg(1'b0);
        xb(8'h05, r); chk("R9 new opcode resp", r, 8'hFF);
        xb(8'h00, r); chk("R10 wen cleared after held write", r, 8'h00);
        open_at(8'h03, 1'b1, 24'h000010);
        xb(8'h00, r); chk("R9 held byte 0", r, 8'h11);
        xb(8'h00, r); chk("R9 held byte 1", r, 8'h22);

        // R8 unsupported opcode
        cfg(1'b0);
        for (int i = 0; i < 6; i++) begin xb((i == 0) ? 8'h9F : 8'h00, r); chk("R8 unsupported", r, 8'hFF); end

        // R3 two-byte address and R7 page write ignored on non-flash
        set_kind(2'd2);
        status_op(8'h06, r);
        open_at(8'h0A, 1'b0, 24'h000005);
        xb(8'h77, r); chk("R7 non-flash resp", r, 8'hFF);
        open_at(8'h03, 1'b0, 24'h000005);
        xb(8'h00, r); chk("R3 R7 two-byte addr, no store", r, pat(5));

        // R11 probe opcode
        set_kind(2'd0);
        cfg(1'b0);
        xb(8'h0B, r); chk("R2 probe resp", r, 8'hFF);
        chk("R11 kind forced", {6'd0, mem_kind}, 8'd1);
        set_kind(2'd3);
        cfg(1'b0);
        xb(8'h0B, r);
        chk("R11 kind kept", {6'd0, mem_kind}, 8'd3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule